// File: doc/BRIEF.md
# Counter-Steered Sequence Controller

This block is a small synchronous state machine whose state register is a 4-bit synchronous binary counter. The counter offers three control functions: a synchronous clear (active low), a synchronous parallel load (active low), and a count enable made of two enables that must both be high. Each cycle, combinational steering logic looks at the current state and at a single input `x_in` and picks one function. Clearing returns the machine to state 0. Counting moves it along its main loop, because the loop states are numbered one after another. Loading sends it to any other target.

Only the low three counter bits form the state. The fourth stage is built so that it can never leave 0. Reset is synchronous and active high, and it is folded into the counter clear. Every pin is a plain level signal. The block has no stream interface and applies no back-pressure.

Top module: `seqctl_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state after that edge is 0.
- R2: From states 0, 1 and 3 the next state is the current state plus one, whatever `x_in` is.
- R3: From state 2 the next state is 0 when `x_in` is 0 and 3 when `x_in` is 1.
- R4: From state 4 the next state is 3 when `x_in` is 0 (a parallel load, with load data C=B, B=1, A=C where C is bit 2 and A is bit 0). The next state is 5 when `x_in` is 1.
- R5: From state 5 the state holds at 5 when `x_in` is 0 and moves to 6 when `x_in` is 1.
- R6: From state 6 the next state is 0, whatever `x_in` is.
- R7: Once out of reset, the state never takes the value 7, and the hidden fourth counter bit stays 0.
- R8: If a clear and a load are requested in the same cycle, the clear wins. In state 6 with `x_in`=0, the load data would be 7, but the next state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| x_in | input | 1 | Steering input sampled every cycle |
| state_o | output | 3 | Current machine state (bit 2 = C, bit 0 = A) |

## Verification
The assertions assume that `rst` is held high for at least one edge at time zero, so that the state is defined before any transition property is armed. They also assume that `x_in` is a clean 0 or 1 at every rising edge. The bench changes `x_in` and `rst` only on falling edges. It starts in reset, walks a fixed path that visits every reachable state with both values of `x_in`, adds a mid-run reset, and then drives a pseudo-random `x_in` stream. This keeps each input stable around the sampling edge.

// File: rtl/seqctl_pkg.sv
package seqctl_pkg;
  localparam int CNT_W   = 4;
  localparam int STATE_W = 3;
  typedef logic [STATE_W-1:0] state_t;
  localparam state_t ST_ZERO = '0;
endpackage

// File: rtl/seqctl_counter.sv
// Synchronous binary counter, priority clear > load > count > hold.
// Stages whose bit in LIVE_MASK is 0 are held at 0 permanently.
module seqctl_counter #(
  parameter int               WIDTH     = 4,
  parameter logic [WIDTH-1:0] LIVE_MASK = 4'b0111
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             ld_n,
  input  logic             en_p,
  input  logic             en_t,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH:0] carry;
  assign carry[0] = en_p & en_t;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    assign carry[i+1] = carry[i] & q[i];
    if (LIVE_MASK[i]) begin : g_live
      logic nxt;
      always_comb begin
        if (!clr_n)        nxt = 1'b0;
        else if (!ld_n)    nxt = d[i];
        else if (carry[i]) nxt = ~q[i];
        else               nxt = q[i];
      end
      always_ff @(posedge clk) q[i] <= nxt;
    end else begin : g_dead
      assign q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/seqctl_steer.sv
// Combinational steering from state (C,B,A) and x to counter controls.
module seqctl_steer
  import seqctl_pkg::*;
(
  input  state_t x_state,
  input  logic   x,
  output logic   clr_n,
  output logic   ld_n,
  output logic   cnt_en,
  output state_t ld_val
);
  logic sa, sb, sc;
  assign sa = x_state[0];
  assign sb = x_state[1];
  assign sc = x_state[2];

  assign clr_n  = sa | ~sb | (x & ~sc);
  assign ld_n   = sa | x | (~sb & ~sc);
  assign cnt_en = x | ~sc;
  assign ld_val = {sb, 1'b1, sc};
endmodule

// File: rtl/seqctl_top.sv
module seqctl_top
  import seqctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       x_in,
  output logic [2:0] state_o
);
  localparam logic [CNT_W-1:0] LIVE = CNT_W'((1 << STATE_W) - 1);

  state_t           cur;
  logic             st_clr_n, st_ld_n, st_cnt;
  state_t           st_ld_val;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             clr_eff_n;

  assign cur = cnt_q[STATE_W-1:0];

  seqctl_steer u_steer (
    .x_state (cur),
    .x       (x_in),
    .clr_n   (st_clr_n),
    .ld_n    (st_ld_n),
    .cnt_en  (st_cnt),
    .ld_val  (st_ld_val)
  );

  // Unused upper stages receive load data 0.
  assign cnt_d     = {{(CNT_W-STATE_W){1'b0}}, st_ld_val};
  assign clr_eff_n = st_clr_n & ~rst;

  seqctl_counter #(.WIDTH(CNT_W), .LIVE_MASK(LIVE)) u_cnt (
    .clk   (clk),
    .clr_n (clr_eff_n),
    .ld_n  (st_ld_n),
    .en_p  (st_cnt),
    .en_t  (st_cnt),
    .d     (cnt_d),
    .q     (cnt_q)
  );

  assign state_o = cur;

  a_r1_reset_zero: assert property (@(posedge clk) rst |=> state_o == ST_ZERO);
  a_r2_advance: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd0 || state_o == 3'd1 || state_o == 3'd3)
      |=> state_o == $past(state_o) + 3'd1);
  a_r3_split: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd2) |=> state_o == ($past(x_in) ? 3'd3 : 3'd0));
  a_r4_load: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd4) |=> state_o == ($past(x_in) ? 3'd5 : 3'd3));
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd5) |=> state_o == ($past(x_in) ? 3'd6 : 3'd5));
  a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd6) |=> state_o == 3'd0);
  a_r7_no_seven: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (state_o != 3'd7 && cnt_q[CNT_W-1] == 1'b0));
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (!st_clr_n && !st_ld_n) |=> state_o == ST_ZERO);
endmodule

// File: tb/seqctl_top_test.sv
module seqctl_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       x_in = 1'b0;
  logic [2:0] state_o;

  int checks = 0;
  int errors = 0;
  logic [2:0] model = 3'd0;
  logic [2:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  always #4 clk = ~clk;

  seqctl_top uut (.clk(clk), .rst(rst), .x_in(x_in), .state_o(state_o));

  function automatic logic [2:0] ref_next(input logic [2:0] s, input logic x);
    case (s)
      3'd0, 3'd1, 3'd3: return s + 3'd1;
      3'd2: return x ? 3'd3 : 3'd0;
      3'd4: return x ? 3'd5 : 3'd3;
      3'd5: return x ? 3'd6 : 3'd5;
      default: return 3'd0;
    endcase
  endfunction

  function automatic string ref_tag(input logic [2:0] s, input logic x);
    case (s)
      3'd0, 3'd1, 3'd3: return "R2";
      3'd2: return "R3";
      3'd4: return "R4";
      3'd5: return "R5";
      default: return x ? "R6" : "R8";
    endcase
  endfunction

  task automatic drive(input logic r, input logic x);
    @(negedge clk);
    rst  = r;
    x_in = x;
    if (r) begin
      model = 3'd0;
      exp_q.push_back(3'd0);
      tag_q.push_back("R1");
    end else begin
      tag_q.push_back(ref_tag(model, x));
      model = ref_next(model, x);
      exp_q.push_back(model);
    end
  endtask

  // Monitor: compare each result one time unit after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (state_o !== e) begin
          errors++;
          $display("FAIL %s: state actual=%0d expected=%0d", t, state_o, e);
        end
        if (state_o === 3'd7) begin
          errors++;
          $display("FAIL R7: state actual=7 expected not 7");
        end
      end
    end
  end

  initial begin
    logic [7:0] lfsr;
    lfsr = 8'hA5;
    drive(1'b1, 1'b0);
    drive(1'b1, 1'b1);
    // Directed walk over every reachable (state, x) pair.
    drive(0, 0); drive(0, 1); drive(0, 0);            // 0->1->2->0 (R3)
    drive(0, 1); drive(0, 0); drive(0, 1);            // 0->1->2->3
    drive(0, 0); drive(0, 0); drive(0, 1);            // 3->4->3 (R4) ->4
    drive(0, 1); drive(0, 0); drive(0, 0);            // 4->5, hold, hold (R5)
    drive(0, 1); drive(0, 0);                         // 5->6->0 (R8)
    drive(0, 1); drive(0, 1); drive(0, 1);            // 0->1->2->3
    drive(0, 1); drive(0, 1); drive(0, 1); drive(0, 1); // 3->4->5->6->0 (R6)
    drive(0, 1); drive(0, 1); drive(0, 1);            // 0->1->2->3
    drive(1'b1, 1'b1);                                // mid-run reset (R1)
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      drive(1'b0, lfsr[0]);
    end
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule